// File: doc/BRIEF.md
# Paging Codeword Call Sequencer

This block sits behind the error-correction stage of a paging receiver. It takes one 32-bit codeword per valid strobe. Each codeword arrives with a flag that marks it as uncorrectable. The block sorts each codeword into one of three kinds: address, message or idle. When a clean address codeword matches the receiver's own address, the block opens a call. While the call is open, it forwards the 20-bit payload of each message codeword, tagged with the call type taken from the two function bits.

A call closes normally when an idle or address codeword follows at least one message. It can also close early on uncorrectable codewords. Two static policy inputs select how strict that error rule is. Alert-only calls carry no payload: they open and close in the same cycle. The own-address value, the frame position (which supplies the three low address bits) and the policy bits are plain inputs.

Codeword bits are numbered 1 to 32 from the most significant end, so bit n is `cw_data[32-n]`. All outputs are registered and change on the clock edge that samples the codeword.

Top module: `pcs_call_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `msg_valid`, `call_start`, `call_done` and `call_open` are 0.
- R2: A codeword opens a call when all of these hold: it is valid and not uncorrectable, `cw_data[31]` is 0 (address kind), it is not the idle pattern, and `{cw_data[30:13], frame_pos}` equals `own_addr`. The call then pulses `call_start` for one cycle and sets `call_type` to `cw_data[12:11]`.
- R3: The idle pattern 32'h7A89C197 never opens a call, even when its address field matches. Address codewords that do not match are ignored.
- R4: Call types 2'b01 and 2'b10 are alert only. `call_start` and `call_done` pulse together, `call_open` stays 0, and no payload is forwarded.
- R5: In an open call, a clean codeword with `cw_data[31]`=1 (message kind) gives one `msg_valid` pulse. That pulse carries `msg_data = cw_data[30:11]` and `msg_type` equal to the call type. With no call open, message codewords produce nothing.
- R6: An open call closes when a clean idle or address codeword arrives after at least one message. Closing pulses `call_done` and drops `call_open`. Before the first message, such codewords leave the call open.
- R7: If the closing codeword is itself a matching address, a new call starts in the same cycle as the `call_done` pulse.
- R8: With `pol_a`=0, an uncorrectable codeword closes the call in two cases: it comes directly after the opening address, or the codeword before it was also uncorrectable.
- R9: With `pol_a`=1 and `pol_b`=0, any single uncorrectable codeword closes the call.
- R10: With `pol_a`=1 and `pol_b`=1, only the second of two consecutive uncorrectable codewords closes the call.
- R11: Uncorrectable codewords never open a call and never produce payload.
- R12: A clean codeword between two uncorrectable ones resets the consecutive-error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Codeword strobe |
| cw_data | input | 32 | Corrected codeword, bit 1 in bit 31 |
| cw_uncorr | input | 1 | Codeword could not be corrected |
| frame_pos | input | 3 | Frame index of the codeword, low address bits |
| own_addr | input | 21 | Receiver address |
| pol_a | input | 1 | Error policy select A |
| pol_b | input | 1 | Error policy select B |
| msg_valid | output | 1 | Payload word strobe |
| msg_data | output | 20 | Payload bits 2..21 |
| msg_type | output | 2 | Call type of the payload word |
| call_start | output | 1 | Call opened pulse |
| call_done | output | 1 | Call closed pulse |
| call_open | output | 1 | Call in progress |
| call_type | output | 2 | Function bits of the current call |

## Verification
The bench uses the default parameters: an 18-bit field carried in the codeword plus a 3-bit frame position. With this configuration it can sweep every frame position against every function code, for both a matching and a mismatched address field, and it can test the idle pattern at all eight positions as a matching address. For each of the four policy settings, it runs all eight patterns of clean and uncorrectable codewords over the first three codewords of a call. This covers the directly-after-address rule, single-error closing and the reset of the consecutive-error count.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int CW_W    = 32;
    localparam int PAY_W   = 20;
    localparam int HI_W    = 18;
    localparam int FRAME_W = 3;
    localparam int ADDR_W  = HI_W + FRAME_W;
    localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89C197;

    typedef enum logic [1:0] {
        CT_NUMERIC = 2'b00,
        CT_ALERT_A = 2'b01,
        CT_ALERT_B = 2'b10,
        CT_ALPHA   = 2'b11
    } call_type_e;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_MSG  = 2'd1,
        K_IDLE = 2'd2
    } cw_kind_e;

    typedef struct packed {
        cw_kind_e               kind;
        logic                   err;
        logic                   hit;
        call_type_e             ctype;
        logic [PAY_W-1:0]       payload;
    } cw_info_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_CALL = 1'b1
    } seq_state_e;

    function automatic logic is_alert(input call_type_e t);
        return t[1] ^ t[0];
    endfunction

    function automatic cw_kind_e classify(input logic [CW_W-1:0] cw);
        if (cw == IDLE_CW)      return K_IDLE;
        else if (cw[CW_W-1])    return K_MSG;
        else                    return K_ADDR;
    endfunction
endpackage

// File: rtl/pcs_cw_class.sv
module pcs_cw_class
    import pcs_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic [CW_W-1:0]    cw,
    input  logic               uncorr,
    input  logic [FW-1:0]      frame_pos,
    input  logic [HI_W+FW-1:0] own_addr,
    output cw_info_t           info
);
    localparam int HI_LSB  = CW_W - 1 - HI_W;
    localparam int PAY_LSB = CW_W - 1 - PAY_W;

    logic [HI_W+FW-1:0] full_addr;

    always_comb begin
        full_addr    = {cw[CW_W-2:HI_LSB], frame_pos};
        info.kind    = classify(cw);
        info.err     = uncorr;
        info.hit     = (full_addr == own_addr);
        info.ctype   = call_type_e'(cw[HI_LSB-1:HI_LSB-2]);
        info.payload = cw[CW_W-2:PAY_LSB];
    end
endmodule

// File: rtl/pcs_err_policy.sv
module pcs_err_policy (
    input  logic pol_a,
    input  logic pol_b,
    input  logic prev_err,
    input  logic first_after_addr,
    output logic end_call
);
    always_comb begin
        unique case ({pol_a, pol_b})
            2'b10:   end_call = 1'b1;
            2'b11:   end_call = prev_err;
            default: end_call = prev_err | first_after_addr;
        endcase
    end
endmodule

// File: rtl/pcs_call_seq.sv
module pcs_call_seq
    import pcs_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cw_valid,
    input  logic [CW_W-1:0]      cw_data,
    input  logic                 cw_uncorr,
    input  logic [FW-1:0]        frame_pos,
    input  logic [HI_W+FW-1:0]   own_addr,
    input  logic                 pol_a,
    input  logic                 pol_b,
    output logic                 msg_valid,
    output logic [PAY_W-1:0]     msg_data,
    output logic [1:0]           msg_type,
    output logic                 call_start,
    output logic                 call_done,
    output logic                 call_open,
    output logic [1:0]           call_type
);
    cw_info_t   info;
    logic       end_by_err;

    seq_state_e st_q, st_d;
    call_type_e type_q, type_d;
    logic       seen_q, seen_d;
    logic       prev_q, prev_d;
    logic       first_q, first_d;
    logic       mv_d, cs_d, cd_d;
    logic [PAY_W-1:0] md_d;
    logic       open_req;

    pcs_cw_class #(.FW(FW)) u_class (
        .cw        (cw_data),
        .uncorr    (cw_uncorr),
        .frame_pos (frame_pos),
        .own_addr  (own_addr),
        .info      (info)
    );

    pcs_err_policy u_pol (
        .pol_a            (pol_a),
        .pol_b            (pol_b),
        .prev_err         (prev_q),
        .first_after_addr (first_q),
        .end_call         (end_by_err)
    );

    assign open_req = !info.err && (info.kind == K_ADDR) && info.hit;

    always_comb begin
        st_d    = st_q;
        type_d  = type_q;
        seen_d  = seen_q;
        prev_d  = prev_q;
        first_d = first_q;
        mv_d    = 1'b0;
        cs_d    = 1'b0;
        cd_d    = 1'b0;
        md_d    = '0;
        if (cw_valid) begin
            if (st_q == S_CALL) begin
                if (info.err) begin
                    if (end_by_err) begin
                        cd_d = 1'b1;
                        st_d = S_IDLE;
                    end else begin
                        prev_d  = 1'b1;
                        first_d = 1'b0;
                    end
                end else if (info.kind == K_MSG) begin
                    mv_d    = 1'b1;
                    md_d    = info.payload;
                    seen_d  = 1'b1;
                    prev_d  = 1'b0;
                    first_d = 1'b0;
                end else if (seen_q) begin
                    cd_d = 1'b1;
                    st_d = S_IDLE;
                end else begin
                    prev_d  = 1'b0;
                    first_d = 1'b0;
                end
            end
            if ((st_q == S_IDLE || (cd_d && !info.err)) && open_req) begin
                cs_d   = 1'b1;
                type_d = info.ctype;
                if (is_alert(info.ctype)) begin
                    cd_d = 1'b1;
                    st_d = S_IDLE;
                end else begin
                    st_d    = S_CALL;
                    seen_d  = 1'b0;
                    prev_d  = 1'b0;
                    first_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            type_q     <= CT_NUMERIC;
            seen_q     <= 1'b0;
            prev_q     <= 1'b0;
            first_q    <= 1'b0;
            msg_valid  <= 1'b0;
            msg_data   <= '0;
            call_start <= 1'b0;
            call_done  <= 1'b0;
        end else begin
            st_q       <= st_d;
            type_q     <= type_d;
            seen_q     <= seen_d;
            prev_q     <= prev_d;
            first_q    <= first_d;
            msg_valid  <= mv_d;
            msg_data   <= md_d;
            call_start <= cs_d;
            call_done  <= cd_d;
        end
    end

    assign call_open = (st_q == S_CALL);
    assign call_type = type_q;
    assign msg_type  = type_q;
endmodule

// File: rtl/pcs_call_seq_chk.sv
module pcs_call_seq_chk
    import pcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cw_valid,
    input logic [CW_W-1:0]   cw_data,
    input logic              cw_uncorr,
    input logic              pol_a,
    input logic              pol_b,
    input logic              msg_valid,
    input logic [PAY_W-1:0]  msg_data,
    input logic              call_start,
    input logic              call_done,
    input logic              call_open,
    input logic [1:0]        call_type
);
    AST_MSG_NEEDS_CALL: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(call_open) && $past(cw_valid) && $past(cw_data[CW_W-1]) && !$past(cw_uncorr)); // R5

    AST_MSG_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_data == $past(cw_data[CW_W-2:CW_W-1-PAY_W])); // R5

    AST_START_CLEAN_ADDR: assert property (@(posedge clk) disable iff (rst)
        call_start |-> $past(cw_valid) && !$past(cw_uncorr) && !$past(cw_data[CW_W-1])); // R2

    AST_IDLE_NO_OPEN: assert property (@(posedge clk) disable iff (rst)
        $past(cw_valid && cw_data == IDLE_CW) |-> !call_start); // R3

    AST_ALERT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (call_start && (call_type[1] ^ call_type[0])) |-> call_done && !call_open); // R4

    AST_SINGLE_ERR_END: assert property (@(posedge clk) disable iff (rst)
        $past(call_open && cw_valid && cw_uncorr && pol_a && !pol_b) |-> call_done && !call_open); // R9

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        $past(cw_valid && cw_uncorr) |-> !call_start && !msg_valid); // R11

    AST_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        !$past(cw_valid) |-> !msg_valid && !call_start && !call_done); // R1
endmodule

bind pcs_call_seq pcs_call_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cw_valid   (cw_valid),
    .cw_data    (cw_data),
    .cw_uncorr  (cw_uncorr),
    .pol_a      (pol_a),
    .pol_b      (pol_b),
    .msg_valid  (msg_valid),
    .msg_data   (msg_data),
    .call_start (call_start),
    .call_done  (call_done),
    .call_open  (call_open),
    .call_type  (call_type)
);

// File: tb/sim_pcs_call_seq.sv
`timescale 1ns/1ps
module sim_pcs_call_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cw_valid = 1'b0;
    logic [31:0] cw_data = '0;
    logic        cw_uncorr = 1'b0;
    logic [2:0]  frame_pos = '0;
    logic [20:0] own_addr;
    logic        pol_a = 1'b0;
    logic        pol_b = 1'b0;
    logic        msg_valid;
    logic [19:0] msg_data;
    logic [1:0]  msg_type;
    logic        call_start;
    logic        call_done;
    logic        call_open;
    logic [1:0]  call_type;

    localparam logic [31:0] IDLE = 32'h7A89C197;
    localparam logic [17:0] MYHI = 18'h2B4C5;
    localparam logic [2:0]  MYPOS = 3'd5;

    int n_chk = 0;
    int n_bad = 0;

    logic       m_open = 0, m_seen = 0, m_first = 0, m_prev = 0;
    logic [1:0] m_type = 0;

    always #2.5 clk = ~clk;

    pcs_call_seq u0 (
        .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_data(cw_data),
        .cw_uncorr(cw_uncorr), .frame_pos(frame_pos), .own_addr(own_addr),
        .pol_a(pol_a), .pol_b(pol_b), .msg_valid(msg_valid), .msg_data(msg_data),
        .msg_type(msg_type), .call_start(call_start), .call_done(call_done),
        .call_open(call_open), .call_type(call_type)
    );

    function automatic logic [31:0] mk_addr(input logic [17:0] hi, input logic [1:0] fn);
        return {1'b0, hi, fn, 10'h155, 1'b1};
    endfunction

    function automatic logic [31:0] mk_msg(input logic [19:0] pay);
        return {1'b1, pay, 10'h2AA, 1'b0};
    endfunction

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] cw, input logic unc, input logic [2:0] pos, input string tag);
        logic e_msg, e_start, e_done, is_addr, is_idle, hit, endc;
        logic [19:0] e_data;
        e_msg = 0; e_start = 0; e_done = 0; e_data = '0;
        is_idle = (cw == IDLE);
        is_addr = !cw[31] && !is_idle;
        hit = ({cw[30:13], pos} == own_addr);
        if (m_open) begin
            if (unc) begin
                endc = pol_a ? (pol_b ? m_prev : 1'b1) : (m_prev || m_first);
                if (endc) begin e_done = 1; m_open = 0; end
                else begin m_prev = 1; m_first = 0; end
            end else if (cw[31] && !is_idle) begin
                e_msg = 1; e_data = cw[30:11]; m_seen = 1; m_prev = 0; m_first = 0;
            end else if (m_seen) begin
                e_done = 1; m_open = 0;
                if (is_addr && hit) begin
                    e_start = 1; m_type = cw[12:11];
                    if (cw[12] ^ cw[11]) e_done = 1;
                    else begin m_open = 1; m_seen = 0; m_prev = 0; m_first = 1; end
                end
            end else begin
                m_prev = 0; m_first = 0;
            end
        end else if (!unc && is_addr && hit) begin
            e_start = 1; m_type = cw[12:11];
            if (cw[12] ^ cw[11]) e_done = 1;
            else begin m_open = 1; m_seen = 0; m_prev = 0; m_first = 1; end
        end
        @(negedge clk);
        cw_data = cw; cw_uncorr = unc; frame_pos = pos; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0; cw_uncorr = 1'b0;
        check(tag, msg_valid == e_msg, "msg_valid", 64'(msg_valid), 64'(e_msg));
        check(tag, call_start == e_start, "call_start", 64'(call_start), 64'(e_start));
        check(tag, call_done == e_done, "call_done", 64'(call_done), 64'(e_done));
        check(tag, call_open == m_open, "call_open", 64'(call_open), 64'(m_open));
        if (e_msg) begin
            check(tag, msg_data == e_data, "msg_data", 64'(msg_data), 64'(e_data));
            check(tag, msg_type == m_type, "msg_type", 64'(msg_type), 64'(m_type));
        end
        if (e_start)
            check(tag, call_type == m_type, "call_type", 64'(call_type), 64'(m_type));
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        own_addr = {MYHI, MYPOS};
        repeat (3) @(negedge clk);
        check("R1", !msg_valid && !call_start && !call_done && !call_open, "reset outs",
              {60'd0, msg_valid, call_start, call_done, call_open}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", !msg_valid && !call_start && !call_done && !call_open, "post-reset outs",
              {60'd0, msg_valid, call_start, call_done, call_open}, 64'd0);

        // R2 R3 R4 R6: sweep frame position, function code, match
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 4; f++) begin
                for (int h = 0; h < 2; h++) begin
                    send(mk_addr(h != 0 ? MYHI : MYHI ^ 18'h1, 2'(f)), 1'b0, 3'(p), "R2");
                    send(mk_msg(20'(p * 4096 + f * 16 + h + 1)), 1'b0, 3'(p), "R5");
                    send(IDLE, 1'b0, 3'(p), "R6");
                end
            end
        end

        // R5 R11: messages and errors with no call open
        send(mk_msg(20'hABCDE), 1'b0, MYPOS, "R5");
        send(mk_addr(MYHI, 2'b00), 1'b1, MYPOS, "R11");

        // R6: idle and address before first message keep the call open
        send(mk_addr(MYHI, 2'b11), 1'b0, MYPOS, "R2");
        send(IDLE, 1'b0, MYPOS, "R6");
        send(mk_addr(MYHI, 2'b00), 1'b0, MYPOS, "R6");
        send(mk_msg(20'h12345), 1'b0, MYPOS, "R5");
        // R7: matching address closes and reopens
        send(mk_addr(MYHI, 2'b00), 1'b0, MYPOS, "R7");
        send(mk_msg(20'h0F0F0), 1'b0, MYPOS, "R5");
        send(mk_addr(MYHI ^ 18'h3, 2'b00), 1'b0, MYPOS, "R6");
        send(mk_addr(MYHI, 2'b11), 1'b0, MYPOS, "R2");
        send(mk_msg(20'hFFFFF), 1'b0, MYPOS, "R5");
        send(mk_addr(MYHI, 2'b10), 1'b0, MYPOS, "R7");

        // R3: idle pattern as own address at every frame position
        for (int p = 0; p < 8; p++) begin
            own_addr = {IDLE[30:13], 3'(p)};
            send(IDLE, 1'b0, 3'(p), "R3");
        end
        own_addr = {MYHI, MYPOS};

        // R8 R9 R10 R12: policies against error patterns
        for (int pa = 0; pa < 2; pa++) begin
            for (int pb = 0; pb < 2; pb++) begin
                pol_a = 1'(pa); pol_b = 1'(pb);
                for (int pat = 0; pat < 8; pat++) begin
                    send(mk_addr(MYHI, 2'b00), 1'b0, MYPOS, "R2");
                    for (int i = 0; i < 3; i++)
                        send(mk_msg(20'(pat * 16 + i)), pat[i],
                             MYPOS, pa == 0 ? "R8" : (pb == 0 ? "R9" : "R10"));
                    send(mk_msg(20'h00777), 1'b1, MYPOS, "R12");
                    send(IDLE, 1'b0, MYPOS, "R6");
                    send(IDLE, 1'b1, MYPOS, "R11");
                    send(IDLE, 1'b1, MYPOS, "R11");
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule